// File: doc/BRIEF.md
# Per-Pin Edge Sense and Interrupt Unit

This unit watches 32 synchronous input pins. Each pin has its own edge detector and a sticky event flag. A 2-bit sense code per pin decides which transitions set the flag: rising only, falling only, both, or none. Software reads the flags over a simple register port. It clears a flag by writing a one to that flag's bit. A mask selects which flags drive the single interrupt line. The same register port also holds a direction register, which drives the output-enable of each pin. The top four pins can only be inputs.

The sense codes for the 32 pins are packed into two registers. The low register holds pins 0 to 15 and the high register holds pins 16 to 31. Within each register the lowest-numbered pin sits in the top two bits. The event, mask and direction registers all place pin 0 in the most significant bit.

The interrupt comes from a two-state machine. In state IRQ_QUIET the line is low. The transition QUIET_TO_RAISED happens on a clock edge where at least one unmasked flag is set. In state IRQ_RAISED the line is high. The transition RAISED_TO_QUIET happens on a clock edge where no unmasked flag is set. Otherwise the machine holds its state.

Top module: `gpio_sense_unit`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low and `dir_o` is 0.
- R2: The sense code of pin p is in register 0x14 when p < 16 and in register 0x18 otherwise. It occupies the two bits that start at bit (15 - (p mod 16)) * 2.
- R3: Sense code 2'b01 sets the pin's event on a 0-to-1 transition only.
- R4: Sense code 2'b10 sets the pin's event on a 1-to-0 transition only.
- R5: Sense code 2'b00 sets the pin's event on either transition.
- R6: Sense code 2'b11 never sets the pin's event.
- R7: The event register is at 0x0C, with pin p at bit 31 - p. Writing a 1 to a bit clears that event, and writing a 0 leaves the event unchanged. If an edge arrives in the same cycle as the clear, the event stays set.
- R8: The mask register is at 0x10, with pin p at bit 31 - p. `irq_o` goes high one clock after the first edge at which an event is set under a mask bit of 1. It goes low one clock after the first edge at which no such event remains.
- R9: The direction register is at 0x00, with pin p at bit 31 - p, and it drives `dir_o[p]`. The bits for pins 28 to 31 read 0 and ignore writes.
- R10: Rewriting a pin's sense code while the pin is held at a steady level creates no event.
- R11: An event stays set, whether masked or not, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_i | input | 32 | Pin levels, already synchronous to `clk` |
| dir_o | output | 32 | Output enable per pin (1 = drive) |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the unit with its default parameters: 32 pins, two sense registers and input-only pins from 28 upward. At that size every pin can be paired with every sense code. For each pair the bench makes one rising and one falling transition while all other pins are set to code 11. A field placed at the wrong shift or in the wrong register therefore shows up as a missing or stray event. Directed cases then cover the same-cycle clash between an edge and a clear, mode rewrites on a held pin, the one-cycle interrupt latency, and the input-only direction bits.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_BOTH = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_OFF  = 2'b11
    } sense_mode_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int OFS_DIR      = 'h00;
    localparam int OFS_EVENT    = 'h0C;
    localparam int OFS_MASK     = 'h10;
    localparam int OFS_SENSE_LO = 'h14;
    localparam int OFS_SENSE_HI = 'h18;

endpackage

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
    import gpio_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_i,
    input  sense_mode_e mode_i,
    input  logic        clr_i,
    output logic        evt_o
);

    logic prev_q;
    logic hit;
    logic evt_q;

    // The previous level follows the pin in every mode, so a mode change
    // never fabricates an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    always_comb begin
        unique case (mode_i)
            SENSE_RISE: hit = pin_i & ~prev_q;
            SENSE_FALL: hit = ~pin_i & prev_q;
            SENSE_BOTH: hit = pin_i ^ prev_q;
            default:    hit = 1'b0;
        endcase
    end

    // A new edge wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= (evt_q & ~clr_i) | hit;
    end

    assign evt_o = evt_q;

    // R11: a set event survives any cycle without a clear.
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && !clr_i) |=> evt_q);

    // R7: a clear with no concurrent edge empties the flag.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !evt_q);

    // R6: the reserved code never raises a flag.
    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_OFF && !evt_q) |=> !evt_q);

endmodule

// File: rtl/gpio_irq_fsm.sv
module gpio_irq_fsm
    import gpio_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending_i) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> irq_o);

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !irq_o);

endmodule

// File: rtl/gpio_sense_unit.sv
module gpio_sense_unit
    import gpio_sense_pkg::*;
#(
    parameter int DATA_W           = 32,
    parameter int ADDR_W           = 5,
    parameter int INPUT_ONLY_FIRST = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_i,
    output logic [DATA_W-1:0] dir_o,
    output logic              irq_o
);

    localparam int NUM_PINS     = DATA_W;
    localparam int PINS_PER_REG = DATA_W / 2;
    localparam int FIXED_PINS   = NUM_PINS - INPUT_ONLY_FIRST;
    localparam logic [DATA_W-1:0] DIR_WRITABLE = {DATA_W{1'b1}} << FIXED_PINS;

    logic [DATA_W-1:0]   dir_q, mask_q, sense_lo_q, sense_hi_q;
    logic [NUM_PINS-1:0] evt_pin, clr_pin, mask_pin;
    logic [DATA_W-1:0]   evt_bus;
    logic                wr_dir, wr_evt, wr_mask, wr_lo, wr_hi;
    logic                pending;

    assign wr_dir  = bus_wen && (bus_addr == ADDR_W'(OFS_DIR));
    assign wr_evt  = bus_wen && (bus_addr == ADDR_W'(OFS_EVENT));
    assign wr_mask = bus_wen && (bus_addr == ADDR_W'(OFS_MASK));
    assign wr_lo   = bus_wen && (bus_addr == ADDR_W'(OFS_SENSE_LO));
    assign wr_hi   = bus_wen && (bus_addr == ADDR_W'(OFS_SENSE_HI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= '0;
            mask_q     <= '0;
            sense_lo_q <= '0;
            sense_hi_q <= '0;
        end else begin
            if (wr_dir)  dir_q      <= bus_wdata & DIR_WRITABLE;
            if (wr_mask) mask_q     <= bus_wdata;
            if (wr_lo)   sense_lo_q <= bus_wdata;
            if (wr_hi)   sense_hi_q <= bus_wdata;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BUS_BIT = NUM_PINS - 1 - p;
        localparam int SHIFT   = (PINS_PER_REG - 1 - (p % PINS_PER_REG)) * 2;
        logic [1:0] field;

        if (p < PINS_PER_REG) begin : g_lo
            assign field = sense_lo_q[SHIFT +: 2];
        end else begin : g_hi
            assign field = sense_hi_q[SHIFT +: 2];
        end

        assign clr_pin[p]       = wr_evt & bus_wdata[BUS_BIT];
        assign mask_pin[p]      = mask_q[BUS_BIT];
        assign evt_bus[BUS_BIT] = evt_pin[p];
        assign dir_o[p]         = dir_q[BUS_BIT];

        gpio_edge_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[p]),
            .mode_i (sense_mode_e'(field)),
            .clr_i  (clr_pin[p]),
            .evt_o  (evt_pin[p])
        );
    end

    assign pending = |(evt_pin & mask_pin);

    gpio_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_o     (irq_o)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_DIR):      bus_rdata = dir_q;
            ADDR_W'(OFS_EVENT):    bus_rdata = evt_bus;
            ADDR_W'(OFS_MASK):     bus_rdata = mask_q;
            ADDR_W'(OFS_SENSE_LO): bus_rdata = sense_lo_q;
            ADDR_W'(OFS_SENSE_HI): bus_rdata = sense_hi_q;
            default:               bus_rdata = '0;
        endcase
    end

    // R9: a direction write leaves the input-only pins undriven.
    p_inonly_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_o[NUM_PINS-1:INPUT_ONLY_FIRST] == '0));

endmodule

// File: tb/tb_gpio_sense_unit.sv
module tb_gpio_sense_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_i = '0;
    logic [31:0] dir_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    gpio_sense_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .dir_o(dir_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] word;
        int sh;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        foreach (v[i]) ;
        rd(5'h00, v); check("R1 dir", v, 32'h0);
        rd(5'h0C, v); check("R1 event", v, 32'h0);
        rd(5'h10, v); check("R1 mask", v, 32'h0);
        rd(5'h14, v); check("R1 sense lo", v, 32'h0);
        rd(5'h18, v); check("R1 sense hi", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 dir_o", dir_o, 32'h0);

        // R2 with R3 R4 R5 R6: every pin against every sense code
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] bit_p;
                logic rise_ok, fall_ok;
                string tag;
                bit_p = 32'h1 << (31 - p);
                sh = (15 - (p % 16)) * 2;
                word = ~(32'h3 << sh) | (32'(m) << sh);
                if (p < 16) begin wr(5'h14, word); wr(5'h18, '1); end
                else        begin wr(5'h14, '1);   wr(5'h18, word); end
                rise_ok = (m == 0) || (m == 1);
                fall_ok = (m == 0) || (m == 2);
                tag = (m == 0) ? "R5" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R6";
                pin_i[p] = 1'b1;
                step();
                rd(5'h0C, v);
                check($sformatf("R2 %s rise pin%0d", tag, p), v, rise_ok ? bit_p : 32'h0);
                wr(5'h0C, '1);
                pin_i[p] = 1'b0;
                step();
                rd(5'h0C, v);
                check($sformatf("R2 %s fall pin%0d", tag, p), v, fall_ok ? bit_p : 32'h0);
                wr(5'h0C, '1);
            end
        end

        // R10: mode rewrites on a held-high pin
        wr(5'h14, '1); wr(5'h18, '1);
        pin_i[7] = 1'b1; pin_i[20] = 1'b1;
        step(); step();
        wr(5'h14, ~(32'h3 << 16) | (32'h1 << 16));
        wr(5'h18, 32'h0);
        step();
        rd(5'h0C, v); check("R10 rewrite on held pins", v, 32'h0);
        wr(5'h14, 32'h0);
        rd(5'h0C, v); check("R10 switch to both", v, 32'h0);
        wr(5'h14, '1); wr(5'h18, '1);
        pin_i = '0; step();
        wr(5'h0C, '1);

        // R7: edge and clear in the same cycle, write-zero has no effect
        wr(5'h14, 32'h0); wr(5'h18, 32'h0);
        pin_i[5] = 1'b1;
        bus_wen = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h1 << 26;
        step();
        bus_wen = 1'b0;
        rd(5'h0C, v); check("R7 edge beats clear", v, 32'h1 << 26);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v); check("R7 zero write keeps", v, 32'h1 << 26);
        wr(5'h0C, 32'h1 << 26);
        rd(5'h0C, v); check("R7 one write clears", v, 32'h0);
        wr(5'h14, '1); wr(5'h18, '1);
        pin_i = '0; step();
        wr(5'h0C, '1);

        // R8 and R11: mask and interrupt timing
        wr(5'h14, 32'h5555_5555); wr(5'h18, 32'h5555_5555);
        wr(5'h10, 32'h1 << 28);
        rd(5'h10, v); check("R8 mask readback", v, 32'h1 << 28);
        pin_i[3] = 1'b1;
        step();
        rd(5'h0C, v); check("R8 event pin3", v, 32'h1 << 28);
        check("R8 irq not yet", {31'b0, irq_o}, 32'h0);
        step();
        check("R8 irq raised", {31'b0, irq_o}, 32'h1);
        wr(5'h0C, 32'h1 << 28);
        check("R8 irq held one cycle", {31'b0, irq_o}, 32'h1);
        step();
        check("R8 irq dropped", {31'b0, irq_o}, 32'h0);
        pin_i[9] = 1'b1;
        step(); step(); step();
        check("R8 masked event silent", {31'b0, irq_o}, 32'h0);
        rd(5'h0C, v); check("R11 masked event sticky", v, 32'h1 << 22);
        wr(5'h10, 32'h1 << 22);
        check("R8 unmask not yet", {31'b0, irq_o}, 32'h0);
        step();
        check("R8 unmask raises", {31'b0, irq_o}, 32'h1);
        wr(5'h10, 32'h0);
        step();
        check("R8 remask drops", {31'b0, irq_o}, 32'h0);
        rd(5'h0C, v); check("R11 still set after mask", v, 32'h1 << 22);

        // R9: direction register and input-only pins
        wr(5'h00, '1);
        rd(5'h00, v); check("R9 dir readback", v, 32'hFFFF_FFF0);
        check("R9 dir_o all", dir_o, 32'h0FFF_FFFF);
        wr(5'h00, 32'h8000_0001);
        rd(5'h00, v); check("R9 dir pin31 ignored", v, 32'h8000_0000);
        check("R9 dir_o pin0", dir_o, 32'h0000_0001);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule